// File: doc/BRIEF.md
# Half-Duplex Line Direction Controller

This block steers the direction-enable (RTS) line of an external half-duplex line driver on behalf of a UART transmitter. When data is waiting to be sent, it raises RTS. It then holds back the transmitter's start permit for a programmable number of bit intervals, so the external driver has time to turn on and the line can settle. After the stop bit of the final character, it keeps RTS high for a second programmable number of bit intervals and then releases the line.

The same trailing interval also bounds a receive-ignore window. The local receiver uses this window to discard the echo of its own transmission. Both delays are counted on a bit-interval tick supplied from outside. Because the baud generator produces that tick after any rate multiplication, the delays stay correct at every rate setting. When the automatic mode is off, RTS simply follows a software-set level and the transmitter may start at any time.

Top module: `hdx_dir_ctrl`

## Requirements
- R1: After reset, with automatic mode on and no pending data, RTS, start permit and receive-ignore are all low.
- R2: The upper DLY_W bits of the delay register give the lead-in (setup) count and the lower DLY_W bits give the trail (hold) count. With the default DLY_W of 4, these are bits 7:4 and 3:0. Both counts are in bit intervals, 0 to 15.
- R3: When pending data is seen while idle, RTS rises on the next clock. Start permit rises only once the lead-in count of bit ticks has been received after that.
- R4: After a stop-bit-done pulse with no data pending, RTS stays high until the trail count of bit ticks has been received. It then falls on the clock edge of the last of those ticks.
- R5: With a lead-in count of zero, RTS and start permit rise on the same clock.
- R6: With a trail count of zero, RTS falls on the clock after the stop-bit-done pulse.
- R7: A stop-bit-done pulse while data is still pending leaves RTS and start permit high, with no new lead-in.
- R8: Data that arrives during the trail interval restores start permit on the next clock, with no lead-in.
- R9: Clock cycles without a bit tick do not advance either delay.
- R10: Receive-ignore is high only when automatic mode and echo suppression are both on, and start permit is high or the trail interval is running.
- R11: With automatic mode off, RTS equals the manual level input, start permit is high, receive-ignore is low, and the controller returns to idle.
- R12: With SNAP_DLY=1, each delay count is captured when its interval begins. Writes to the delay register during the interval do not change that interval's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_en | input | 1 | Automatic direction control enable |
| echo_en | input | 1 | Echo suppression enable |
| rts_manual | input | 1 | RTS level used while automatic mode is off |
| dly_reg | input | 2*DLY_W | Lead-in count (upper half) and trail count (lower half) |
| bit_tick | input | 1 | One-cycle pulse per effective bit interval |
| txq_nempty | input | 1 | Transmit queue holds data |
| stop_done | input | 1 | Pulse when the transmitter finishes a stop bit |
| rts_o | output | 1 | Direction enable for the external driver |
| tx_start_ok | output | 1 | Transmitter may begin a character |
| rx_ignore | output | 1 | Receiver should discard incoming data |

## Verification
The bench builds the block with DLY_W=4 and SNAP_DLY=1. This covers the full 0 to 15 range of both counts, including the zero-skip paths and the maximum interval. With snapshot mode on, the bench can rewrite the delay register in the middle of an interval and check that the interval's length does not change. A bench-side phase model tracks a random stream of queue levels, stop pulses, tick spacings, mode toggles and register writes. Directed runs count the ticks between RTS and start-permit edges.

// File: rtl/hdx_pkg.sv
package hdx_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_SEND  = 2'd2,
      PH_HOLD  = 2'd3
   } hdx_phase_e;

   function automatic logic phase_owns_line(hdx_phase_e p);
      return p != PH_IDLE;
   endfunction

   function automatic logic phase_counts(hdx_phase_e p);
      return (p == PH_SETUP) || (p == PH_HOLD);
   endfunction

endpackage

// File: rtl/hdx_bit_timer.sv
module hdx_bit_timer #(
   parameter int W    = 4,
   parameter bit SNAP = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] lim_in,
   input  logic         run,
   input  logic         tick,
   output logic         expired
);

   localparam int CW = W + 1;

   logic [W-1:0] cnt;
   logic [W-1:0] eff_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= '0;
      else if (run && tick)
         cnt <= cnt + 1'b1;
   end

   generate
      if (SNAP) begin : g_snap
         logic [W-1:0] lim_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lim_q <= '0;
            else if (load)
               lim_q <= lim_in;
         end
         assign eff_lim = lim_q;

         // R12: a captured interval never lets the count pass its limit
         p_cnt_below_lim_r12: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> (cnt < lim_q));
      end else begin : g_live
         assign eff_lim = lim_in;
      end
   endgenerate

   assign expired = run && tick &&
                    ((CW'(cnt) + CW'(1)) >= CW'(eff_lim));

endmodule

// File: rtl/hdx_dir_fsm.sv
module hdx_dir_fsm
   import hdx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       auto_en,
   input  logic       txq_nempty,
   input  logic       stop_done,
   input  logic       setup_zero,
   input  logic       hold_zero,
   input  logic       expired,
   output hdx_phase_e ph,
   output logic       load
);

   hdx_phase_e nxt;

   always_comb begin
      nxt = ph;
      unique case (ph)
         PH_IDLE:
            if (txq_nempty) nxt = setup_zero ? PH_SEND : PH_SETUP;
         PH_SETUP:
            if (expired) nxt = PH_SEND;
         PH_SEND:
            if (stop_done && !txq_nempty) nxt = hold_zero ? PH_IDLE : PH_HOLD;
         PH_HOLD:
            if (txq_nempty)   nxt = PH_SEND;
            else if (expired) nxt = PH_IDLE;
         default: nxt = PH_IDLE;
      endcase
      if (!auto_en) nxt = PH_IDLE;
   end

   assign load = ((nxt == PH_SETUP) && (ph != PH_SETUP)) ||
                 ((nxt == PH_HOLD)  && (ph != PH_HOLD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ph <= PH_IDLE;
      else
         ph <= nxt;
   end

   // R8: data arriving in the trail interval goes straight back to sending
   p_resume_no_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && ph == PH_HOLD && txq_nempty |=> ph == PH_SEND || !$past(auto_en) || ph == PH_IDLE);

   // R7: a stop pulse with data pending keeps the send phase
   p_back_to_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && ph == PH_SEND && txq_nempty |=> ph == PH_SEND || ph == PH_IDLE);

endmodule

// File: rtl/hdx_dir_ctrl.sv
module hdx_dir_ctrl
   import hdx_pkg::*;
#(
   parameter int DLY_W    = 4,
   parameter bit SNAP_DLY = 1'b1,
   localparam int REG_W   = 2 * DLY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auto_en,
   input  logic             echo_en,
   input  logic             rts_manual,
   input  logic [REG_W-1:0] dly_reg,
   input  logic             bit_tick,
   input  logic             txq_nempty,
   input  logic             stop_done,
   output logic             rts_o,
   output logic             tx_start_ok,
   output logic             rx_ignore
);

   generate
      if (DLY_W < 1 || DLY_W > 8) begin : g_bad_width
         $error("hdx_dir_ctrl: DLY_W must lie in 1..8");
      end
   endgenerate

   logic [DLY_W-1:0] setup_f;
   logic [DLY_W-1:0] hold_f;
   logic [DLY_W-1:0] lim_sel;
   hdx_phase_e       ph;
   logic             load;
   logic             expired;
   logic             run;

   // R2: lead-in count in the upper half, trail count in the lower half
   assign setup_f = dly_reg[REG_W-1:DLY_W];
   assign hold_f  = dly_reg[DLY_W-1:0];

   // a single timer serves both intervals; the phase picks its limit
   assign lim_sel = ((ph == PH_SEND) || (ph == PH_HOLD)) ? hold_f : setup_f;
   assign run     = phase_counts(ph);

   hdx_dir_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_en),
      .txq_nempty (txq_nempty),
      .stop_done  (stop_done),
      .setup_zero (setup_f == '0),
      .hold_zero  (hold_f == '0),
      .expired    (expired),
      .ph         (ph),
      .load       (load)
   );

   hdx_bit_timer #(
      .W    (DLY_W),
      .SNAP (SNAP_DLY)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .lim_in  (lim_sel),
      .run     (run),
      .tick    (bit_tick),
      .expired (expired)
   );

   assign rts_o       = auto_en ? phase_owns_line(ph) : rts_manual;
   assign tx_start_ok = auto_en ? (ph == PH_SEND) : 1'b1;
   assign rx_ignore   = auto_en && echo_en && ((ph == PH_SEND) || (ph == PH_HOLD));

   // R3: leaving the lead-in for the send phase happens only on a bit tick
   p_start_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && $past(auto_en) && $rose(tx_start_ok) && $past(ph) == PH_SETUP
      |-> $past(bit_tick));

   // R4 / R6: in automatic mode RTS drops only out of the trail interval
   // or right after a final stop bit
   p_fall_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && $past(auto_en) && $fell(rts_o)
      |-> ($past(ph) == PH_HOLD) || ($past(ph) == PH_SEND && $past(stop_done)));

   // R9: no tick, no progress out of the lead-in
   p_no_tick_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && ph == PH_SETUP && !bit_tick |=> ph != PH_SEND);

   // R10: the ignore window never extends beyond RTS
   p_ignore_inside_rts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      auto_en && rx_ignore |-> rts_o);

endmodule

// File: tb/hdx_dir_ctrl_bench.sv
module hdx_dir_ctrl_bench;

   localparam int DW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic auto_en = 1'b0;
   logic echo_en = 1'b0;
   logic rts_manual = 1'b0;
   logic bit_tick = 1'b0;
   logic txq_nempty = 1'b0;
   logic stop_done = 1'b0;
   logic [2*DW-1:0] dly_reg = '0;
   logic rts_o, tx_start_ok, rx_ignore;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   hdx_dir_ctrl #(.DLY_W(DW), .SNAP_DLY(1'b1)) u_hdx_dir_ctrl (
      .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .echo_en(echo_en),
      .rts_manual(rts_manual), .dly_reg(dly_reg), .bit_tick(bit_tick),
      .txq_nempty(txq_nempty), .stop_done(stop_done),
      .rts_o(rts_o), .tx_start_ok(tx_start_ok), .rx_ignore(rx_ignore)
   );

   // phase model: 0 idle, 1 lead-in, 2 sending, 3 trail
   int m_ph = 0;
   int m_n = 0;
   int m_lim = 0;

   function automatic int lead_of(logic [2*DW-1:0] r);
      return int'(r[2*DW-1:DW]);
   endfunction

   function automatic int trail_of(logic [2*DW-1:0] r);
      return int'(r[DW-1:0]);
   endfunction

   function automatic int expect_outs(int p, logic au, logic ec, logic man);
      logic e_rts, e_ok, e_ign;
      e_rts = au ? (p != 0) : man;
      e_ok  = au ? (p == 2) : 1'b1;
      e_ign = au && ec && (p >= 2);
      return {29'd0, e_rts, e_ok, e_ign};
   endfunction

   always @(posedge clk) begin
      if (!rst_n || !auto_en) begin
         m_ph = 0;
         m_n = 0;
      end else begin
         case (m_ph)
            0: if (txq_nempty) begin
                  if (lead_of(dly_reg) == 0) m_ph = 2;
                  else begin m_ph = 1; m_n = 0; m_lim = lead_of(dly_reg); end
               end
            1: if (bit_tick) begin
                  if (m_n + 1 >= m_lim) m_ph = 2; else m_n = m_n + 1;
               end
            2: if (stop_done && !txq_nempty) begin
                  if (trail_of(dly_reg) == 0) m_ph = 0;
                  else begin m_ph = 3; m_n = 0; m_lim = trail_of(dly_reg); end
               end
            default: if (txq_nempty) m_ph = 2;
               else if (bit_tick) begin
                  if (m_n + 1 >= m_lim) m_ph = 0; else m_n = m_n + 1;
               end
         endcase
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic cycle(logic tk);
      bit_tick = tk;
      #2;
      check("R3 R4 R10 R11", "outputs {rts,ok,ign} vs phase model",
            {29'd0, rts_o, tx_start_ok, rx_ignore},
            expect_outs(m_ph, auto_en, echo_en, rts_manual));
      @(negedge clk);
   endtask

   task automatic count_to_ok(output int ticks);
      ticks = 0;
      for (int i = 0; i < 200; i++) begin
         logic tk;
         if (tx_start_ok) break;
         tk = (i % 3 == 2);
         if (tk && rts_o) ticks++;
         cycle(tk);
      end
   endtask

   task automatic count_to_low(output int ticks);
      ticks = 0;
      for (int i = 0; i < 200; i++) begin
         logic tk;
         if (!rts_o) break;
         tk = (i % 3 == 2);
         if (tk) ticks++;
         cycle(tk);
      end
   endtask

   task automatic finish_send();
      txq_nempty = 1'b0;
      stop_done = 1'b1;
      cycle(1'b0);
      stop_done = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      #3000000;
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL R1 watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int t;
      int seed;
      seed = int'($urandom(32'h5EED0042));
      auto_en = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check("R1", "rts after reset", int'(rts_o), 0);
      check("R1", "start permit after reset", int'(tx_start_ok), 0);
      check("R1", "ignore after reset", int'(rx_ignore), 0);

      // R2 R3 R4 R10: lead-in 3, trail 2
      dly_reg = 8'h32;
      echo_en = 1'b1;
      cycle(1'b0);
      cycle(1'b0);
      txq_nempty = 1'b1;
      cycle(1'b0);
      check("R3", "rts up before permit", {30'd0, rts_o, tx_start_ok}, 2);
      count_to_ok(t);
      check("R2 R3", "lead-in ticks", t, 3);
      check("R10", "ignore while sending", int'(rx_ignore), 1);
      finish_send();
      check("R4", "rts held in trail", {30'd0, rts_o, tx_start_ok}, 2);
      check("R10", "ignore in trail", int'(rx_ignore), 1);
      count_to_low(t);
      check("R2 R4", "trail ticks", t, 2);
      check("R10", "ignore after trail", int'(rx_ignore), 0);

      // R5 R6: zero counts
      dly_reg = 8'h00;
      txq_nempty = 1'b1;
      cycle(1'b0);
      check("R5", "rts and permit together", {30'd0, rts_o, tx_start_ok}, 3);
      finish_send();
      check("R6", "rts down after stop", int'(rts_o), 0);

      // R7: back-to-back characters
      dly_reg = 8'h21;
      txq_nempty = 1'b1;
      cycle(1'b0);
      count_to_ok(t);
      stop_done = 1'b1;
      cycle(1'b0);
      stop_done = 1'b0;
      check("R7", "line kept between characters", {30'd0, rts_o, tx_start_ok}, 3);
      stop_done = 1'b1;
      cycle(1'b1);
      stop_done = 1'b0;
      check("R7", "line kept after second stop", {30'd0, rts_o, tx_start_ok}, 3);
      finish_send();
      count_to_low(t);
      check("R4", "trail of one tick", t, 1);

      // R9 R8
      dly_reg = 8'h25;
      txq_nempty = 1'b1;
      cycle(1'b0);
      repeat (10) cycle(1'b0);
      check("R9", "no progress without ticks", {30'd0, rts_o, tx_start_ok}, 2);
      count_to_ok(t);
      check("R9", "lead-in still two ticks", t, 2);
      finish_send();
      cycle(1'b1);
      txq_nempty = 1'b1;
      cycle(1'b0);
      check("R8", "resume without lead-in", {30'd0, rts_o, tx_start_ok}, 3);
      finish_send();
      count_to_low(t);
      check("R4", "full trail after resume", t, 5);

      // R12: snapshot of counts
      dly_reg = 8'h41;
      txq_nempty = 1'b1;
      cycle(1'b0);
      dly_reg = 8'h11;
      count_to_ok(t);
      check("R12", "lead-in kept despite rewrite", t, 4);
      finish_send();
      dly_reg = 8'h1F;
      count_to_low(t);
      check("R12", "trail kept despite rewrite", t, 1);

      // R10 R11
      dly_reg = 8'h00;
      echo_en = 1'b0;
      txq_nempty = 1'b1;
      cycle(1'b0);
      check("R10", "no ignore with echo off", int'(rx_ignore), 0);
      auto_en = 1'b0;
      rts_manual = 1'b1;
      #1;
      check("R11", "manual high {rts,ok,ign}", {29'd0, rts_o, tx_start_ok, rx_ignore}, 6);
      cycle(1'b0);
      rts_manual = 1'b0;
      #1;
      check("R11", "manual low {rts,ok,ign}", {29'd0, rts_o, tx_start_ok, rx_ignore}, 2);
      txq_nempty = 1'b0;
      cycle(1'b0);
      auto_en = 1'b1;
      cycle(1'b0);
      check("R11", "idle after mode off", {30'd0, rts_o, tx_start_ok}, 0);

      // constrained random run against the phase model
      for (int k = 0; k < 6000; k++) begin
         if ($urandom % 300 == 0) auto_en = ~auto_en;
         if ($urandom % 150 == 0) dly_reg = 8'($urandom);
         if ($urandom % 90 == 0) echo_en = ~echo_en;
         rts_manual = 1'($urandom);
         if ($urandom % 6 == 0) txq_nempty = ~txq_nempty;
         stop_done = ($urandom % 7 == 0);
         cycle($urandom % 3 == 0);
      end
      stop_done = 1'b0;

      finished = 1'b1;
      summary();
      $finish;
   end

endmodule